// File: doc/BRIEF.md
# Packed Decimal to Character Serializer

This block accepts one packed-decimal word, in which every 4-bit nibble carries one decimal digit, two digits to a byte and the most significant digit in the highest nibble. It returns the digits as a stream of 8-bit character codes, one per accepted output beat. Each transfer is produced in one of two character code sets. The code set is selected by a mode input, which is captured together with the word.

A valid/ready handshake loads the word. While the characters drain, the block refuses new words. The character stream follows valid/ready rules: it stalls under back-pressure and marks the final character of each word. An optional mode removes leading zero digits but always keeps at least one digit. A nibble that is not a decimal digit produces a substitute character and raises an error flag. The flag stays high until reset.

Top module: `bcd_char_serializer`

## Requirements
- R1: While reset is held and in the first cycle after it, `in_ready` is 1, `out_valid` is 0, `out_last` is 0 and `err` is 0.
- R2: A word is taken on a rising edge where `in_valid` and `in_ready` are both 1. From the next cycle, `out_valid` is 1 and `in_ready` is 0. They stay that way until the final character of the word has been accepted.
- R3: Characters leave in digit order from the highest nibble (bits DIGITS*4-1 down to DIGITS*4-4) to the lowest nibble (bits 3..0).
- R4: When `in_ebcdic` was 0 at acceptance, a digit d in 0..9 appears as 8'h30 + d. This is a 7-bit code with bit 7 forced to 0.
- R5: When `in_ebcdic` was 1 at acceptance, a digit d in 0..9 appears as 8'hF0 + d.
- R6: `in_word`, `in_ebcdic` and `in_zsup` are sampled only on the accepting edge. Changing them during a transfer has no effect on its characters.
- R7: While `out_valid` is 1 and `out_ready` is 0, the outputs `out_valid`, `out_char` and `out_last` hold their values. The stream advances only on a cycle where both are 1.
- R8: `out_last` is 1 only together with the final character of a word. After that character is accepted, `out_valid` is 0 and `in_ready` is 1 in the next cycle.
- R9: With `in_zsup` at 0, all DIGITS digits are emitted. With `in_zsup` at 1, digits before the first nonzero nibble are skipped. A word whose nibbles are all zero emits only its lowest digit.
- R10: A nibble from 10 to 15 is emitted as 8'h3F in the 7-bit code set and as 8'h6F in the 8-bit code set. It counts as nonzero for R9. `err` becomes 1 on the edge that accepts such a character and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A packed word is offered |
| in_ready | output | 1 | Block is idle and takes a word |
| in_word | input | 4*DIGITS | Packed-decimal word, most significant digit highest |
| in_ebcdic | input | 1 | Code set: 0 = 7-bit code, 1 = 8-bit code |
| in_zsup | input | 1 | 1 = skip leading zero digits |
| out_valid | output | 1 | A character is presented |
| out_ready | input | 1 | Sink accepts the character |
| out_char | output | 8 | Character code |
| out_last | output | 1 | Final character of the word |
| err | output | 1 | Sticky flag for a non-decimal nibble |

## Verification
The bench builds the block with DIGITS = 3, which makes the word 12 bits wide. At that size every one of the 4096 nibble patterns can be swept through all four combinations of code set and zero suppression. Every non-decimal nibble position, and every length of leading-zero run including the all-zero word, is covered in each mode. The output back-pressure follows a repeating stall pattern. This places stalls on first, middle and last characters, and the mode and word inputs are inverted during each transfer.

// File: rtl/bcd_ser_pkg.sv
// Shared constants and types for the packed-decimal serializer.
// Assumes digits are 4-bit codes and characters are 8 bits.
package bcd_ser_pkg;
    typedef enum logic {
        CS_ASCII  = 1'b0,
        CS_EBCDIC = 1'b1
    } charset_e;

    localparam logic [7:0] ASCII_ZERO = 8'h30;
    localparam logic [7:0] EBC_ZERO   = 8'hF0;
    localparam logic [7:0] ASCII_SUB  = 8'h3F;
    localparam logic [7:0] EBC_SUB    = 8'h6F;
    localparam int         NIB_W      = 4;
endpackage

// File: rtl/bcd_digit_mapper.sv
// Maps one 4-bit digit code to a character in the selected code set.
// Purely combinational. A nibble above 9 gives the set's substitute
// character and raises bad.
module bcd_digit_mapper
    import bcd_ser_pkg::*;
(
    input  charset_e   cs,
    input  logic [3:0] digit,
    output logic [7:0] code,
    output logic       bad
);
    // Select the character for the digit; the low nibble carries the value
    always_comb begin
        bad = (digit > 4'd9);
        if (bad)
            code = (cs == CS_EBCDIC) ? EBC_SUB : ASCII_SUB;
        else
            code = ((cs == CS_EBCDIC) ? EBC_ZERO : ASCII_ZERO) | {4'h0, digit};
    end
endmodule

// File: rtl/bcd_lead_zero_scan.sv
// Finds the first digit position, counted from the most significant
// nibble (position 0), whose nibble is not zero. If all nibbles are
// zero it returns the lowest position, DIGITS-1. Combinational.
module bcd_lead_zero_scan #(
    parameter int DIGITS = 8,
    parameter int IW     = 3
) (
    input  logic [4*DIGITS-1:0] word,
    output logic [IW-1:0]       first_idx
);
    logic [DIGITS-1:0] nz;

    // One nonzero detector per digit position, position 0 = top nibble
    for (genvar g = 0; g < DIGITS; g++) begin : g_nz
        assign nz[g] = |word[(DIGITS-1-g)*4 +: 4];
    end

    // Priority pick: the lowest position index with a nonzero nibble wins
    always_comb begin
        first_idx = IW'(DIGITS - 1);
        for (int i = DIGITS - 1; i >= 0; i--) begin
            if (nz[i]) first_idx = IW'(i);
        end
    end
endmodule

// File: rtl/bcd_ser_ctrl.sv
// Transfer controller. It captures the word and the code set on
// acceptance, pre-shifted so that the first emitted digit sits in the
// top nibble. It then shifts one nibble per accepted character and
// counts the characters that remain. It also keeps the sticky error flag.
// Assumes start_idx <= DIGITS-1.
module bcd_ser_ctrl
    import bcd_ser_pkg::*;
#(
    parameter int DIGITS = 8,
    parameter int IW     = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [4*DIGITS-1:0] in_word,
    input  charset_e            in_cs,
    input  logic [IW-1:0]       start_idx,
    output logic                in_ready,
    input  logic                out_ready,
    output logic                out_valid,
    output logic                out_last,
    output logic [3:0]          digit,
    output charset_e            cs_q,
    input  logic                bad,
    output logic                err
);
    localparam int W = 4 * DIGITS;

    logic          busy;
    logic [W-1:0]  word_q;
    logic [IW-1:0] rem;

    // Load a word when idle, otherwise step on each accepted character
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            word_q <= '0;
            rem    <= '0;
            cs_q   <= CS_ASCII;
            err    <= 1'b0;
        end else begin
            if (!busy && in_valid) begin
                busy   <= 1'b1;
                word_q <= in_word << {start_idx, 2'b00};
                rem    <= IW'(DIGITS - 1) - start_idx;
                cs_q   <= in_cs;
            end else if (busy && out_ready) begin
                if (rem == '0) begin
                    busy <= 1'b0;
                end else begin
                    rem    <= rem - 1'b1;
                    word_q <= word_q << 4;
                end
            end
            if (busy && out_ready && bad) err <= 1'b1;
        end
    end

    // Handshake outputs follow the busy state
    assign in_ready  = !busy;
    assign out_valid = busy;
    assign out_last  = busy && (rem == '0);
    assign digit     = word_q[W-1 -: 4];
endmodule

// File: rtl/bcd_char_serializer.sv
// Top level: packed-decimal word in, one character per beat out.
// Ties together the leading-zero scan, the transfer controller and the
// digit-to-character mapper. Assumes DIGITS >= 1.
module bcd_char_serializer
    import bcd_ser_pkg::*;
#(
    parameter int DIGITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [4*DIGITS-1:0] in_word,
    input  logic                in_ebcdic,
    input  logic                in_zsup,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [7:0]          out_char,
    output logic                out_last,
    output logic                err
);
    localparam int IW = (DIGITS > 1) ? $clog2(DIGITS) : 1;

    logic [IW-1:0] first_nz;
    logic [IW-1:0] start_idx;
    logic [3:0]    digit;
    charset_e      cs_q;
    charset_e      in_cs;
    logic          bad;

    bcd_lead_zero_scan #(.DIGITS(DIGITS), .IW(IW)) u_scan (
        .word      (in_word),
        .first_idx (first_nz)
    );

    // Starting position: skip leading zeros only when suppression is asked
    assign start_idx = in_zsup ? first_nz : '0;
    assign in_cs     = in_ebcdic ? CS_EBCDIC : CS_ASCII;

    bcd_ser_ctrl #(.DIGITS(DIGITS), .IW(IW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .in_cs     (in_cs),
        .start_idx (start_idx),
        .in_ready  (in_ready),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_last  (out_last),
        .digit     (digit),
        .cs_q      (cs_q),
        .bad       (bad),
        .err       (err)
    );

    bcd_digit_mapper u_map (
        .cs    (cs_q),
        .digit (digit),
        .code  (out_char),
        .bad   (bad)
    );
endmodule

// File: rtl/bcd_char_serializer_chk.sv
// Port-level protocol checks for bcd_char_serializer, bound to every
// instance of it.
module bcd_char_serializer_chk #(
    parameter int DIGITS = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_char,
    input logic       out_last,
    input logic       err
);
    // R2: no new word is taken while characters are pending
    p_busy_blocks_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R2: an accepted word yields a character in the next cycle
    p_accept_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R7: stalled outputs hold
    p_hold_on_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_char) && $stable(out_last)));

    // R8: the last marker only accompanies a character
    p_last_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R8: accepting the last character frees the block
    p_last_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (!out_valid && in_ready));

    // R4 R5 R10: every presented code belongs to one of the two sets
    p_legal_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_char >= 8'h30 && out_char <= 8'h39) ||
                       (out_char >= 8'hF0 && out_char <= 8'hF9) ||
                       out_char == 8'h3F || out_char == 8'h6F));

    // R10: the error flag never clears outside reset
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

bind bcd_char_serializer bcd_char_serializer_chk #(.DIGITS(DIGITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_char  (out_char),
    .out_last  (out_last),
    .err       (err)
);

// File: tb/bcd_char_serializer_bench.sv
`timescale 1ns/1ps
module bcd_char_serializer_bench;
    localparam int D = 3;
    localparam int W = 4 * D;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_word = '0;
    logic         in_ebcdic = 1'b0;
    logic         in_zsup = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [7:0]   out_char;
    logic         out_last;
    logic         err;

    int checks = 0;
    int errors = 0;
    int stall_ctr = 0;
    logic err_exp = 1'b0;

    always #4 clk = ~clk;

    bcd_char_serializer #(.DIGITS(D)) u_bcd_char_serializer (
        .clk, .rst_n, .in_valid, .in_ready, .in_word, .in_ebcdic, .in_zsup,
        .out_valid, .out_ready, .out_char, .out_last, .err
    );

    task automatic check(input bit ok, input string tag,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_char(input logic [3:0] d, input logic ebc);
        if (d > 4'd9) return ebc ? 8'h6F : 8'h3F;
        return (ebc ? 8'hF0 : 8'h30) + {4'h0, d};
    endfunction

    // Send one word, disturb the inputs, then drain and check every character
    task automatic run_word(input logic [W-1:0] w, input logic ebc, input logic zs);
        int start;
        logic [3:0] d;
        logic [7:0] ec;
        logic lst;
        logic rdy;
        @(negedge clk);
        in_word = w; in_ebcdic = ebc; in_zsup = zs; in_valid = 1'b1;
        check(in_ready === 1'b1, "R2 idle ready", {15'b0, in_ready}, 16'h1);
        @(posedge clk); #1;
        in_valid = 1'b0; in_ebcdic = ~ebc; in_zsup = ~zs; in_word = ~w;   // R6
        start = zs ? D - 1 : 0;
        if (zs) begin
            for (int i = D - 1; i >= 0; i--)
                if (w[(D-1-i)*4 +: 4] != 4'h0) start = i;
        end
        for (int k = start; k < D; k++) begin
            d   = w[(D-1-k)*4 +: 4];
            ec  = exp_char(d, ebc);
            lst = (k == D - 1);
            do begin
                @(negedge clk);
                rdy = ((stall_ctr % 3) != 2);
                stall_ctr++;
                out_ready = rdy;
                check({out_valid, out_last, in_ready, out_char} === {1'b1, lst, 1'b0, ec},
                      "R3 R4 R5 R6 R7 R8 R9 char",
                      {5'b0, out_valid, out_last, in_ready, out_char},
                      {5'b0, 1'b1, lst, 1'b0, ec});
                check(err === err_exp, "R10 err flag", {15'b0, err}, {15'b0, err_exp});
                @(posedge clk);
            end while (!rdy);
            if (d > 4'd9) err_exp = 1'b1;
        end
        @(negedge clk);
        out_ready = 1'b0;
        check(out_valid === 1'b0 && in_ready === 1'b1, "R8 R2 done",
              {14'b0, out_valid, in_ready}, 16'h1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(in_ready === 1'b1 && out_valid === 1'b0 && out_last === 1'b0 && err === 1'b0,
              "R1 reset", {12'b0, in_ready, out_valid, out_last, err}, 16'h8);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready === 1'b1 && out_valid === 1'b0 && err === 1'b0,
              "R1 after reset", {13'b0, in_ready, out_valid, err}, 16'h4);
        for (int m = 0; m < 4; m++) begin
            for (int v = 0; v < (1 << W); v++)
                run_word(W'(v), m[0], m[1]);
        end
        // Reset in the middle of a transfer clears everything (R1)
        @(negedge clk);
        in_word = 12'h123; in_valid = 1'b1;
        @(posedge clk); #1;
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check(in_ready === 1'b1 && out_valid === 1'b0 && err === 1'b0,
              "R1 mid reset", {13'b0, in_ready, out_valid, err}, 16'h4);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule